// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical page address by reading a context table entry and then up to three levels of page tables held in memory. Each step is one 32-bit read over a simple request/acknowledge memory port. The walker classifies the word it got back, then either follows it to the next table, stops with a mapped page, or stops with a fault. A successful walk can end at the first, second or third table level, which gives 16 MB, 256 KB or 4 KB pages. Before finishing, the walker sets the referenced and modified bits of the final entry and writes the entry back when needed.

A requester presents an address, an access kind (read, write or instruction fetch) and a bypass flag, then waits for a one-cycle `done` pulse. The result is either a page-aligned physical address with a size code and a write-permission flag, or a fault code. In bypass mode no memory is touched and the address passes straight through. An optional boot redirect sends instruction fetches to a ROM window. Permission checks against access rights and caching of translations are done elsewhere.

Top module: `tw_top`

## Requirements
- R1: The first read of a walk goes to address (`ctxRoot` << 4) + (`ctxNum` << 2), computed at `PA_W` bits.
- R2: The low two bits of each word read give its kind: 0 invalid, 1 table pointer, 2 leaf, 3 reserved. A pointer read at table level k (context = 0) leads to the read at ((word with bits [1:0] cleared) << 4) + 4×index, where the index is VA[31:24] for k=0, VA[23:18] for k=1 and VA[17:12] for k=2. Each memory request is a single-cycle `memReq` pulse.
- R3: A leaf at level 1, 2 or 3 yields `pageSize` 2 (16 MB), 1 (256 KB) or 0 (4 KB). `physAddr` = ({word[31:8], 8'b0} << 4) + offset, where the offset is {VA[23:12], 12'b0}, {VA[17:12], 12'b0} or 0 respectively.
- R4: An invalid word at level L ends the walk with `fault`=1 and `faultCode` = (L << 8) | (1 << 2).
- R5: A reserved word, a read answered with `memErr`, a leaf in the context table, or a pointer at level 3 ends the walk with `faultCode` = (L << 8) | (4 << 2). L is the level of the read that stopped the walk.
- R6: When the leaf's referenced bit (bit 5) is clear, or the access is a write and its modified bit (bit 6) is clear, the walker sets bit 5, also sets bit 6 for a write, and writes the word back to the address it was read from. Otherwise no write is issued.
- R7: After a successful walk, `permWrite` equals the leaf's modified bit after any update.
- R8: In bypass mode without a boot redirect, `physAddr` is VA with bits [11:0] cleared, `pageSize` is 0, `permWrite` is 1, and no memory request is made.
- R9: In bypass mode with `bootMode` set, an instruction fetch returns `romBase` | {VA[18:12], 12'b0} with `permWrite` 0. Non-fetch accesses ignore `bootMode`.
- R10: `done` is high for exactly one cycle per accepted request. `reqValid` is accepted only while the walker is idle, and is ignored during a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a translation (taken only when idle) |
| reqVa | input | 32 | Virtual address |
| reqWrite | input | 1 | Access is a write |
| reqFetch | input | 1 | Access is an instruction fetch |
| bypass | input | 1 | Physical addressing, no walk |
| bootMode | input | 1 | Redirect bypassed fetches to ROM |
| ctxRoot | input | 32 | Context table pointer register |
| ctxNum | input | CTX_W | Context number |
| romBase | input | PA_W | Boot ROM base address |
| memReq | output | 1 | Memory request pulse |
| memWe | output | 1 | Request is a write |
| memAddr | output | PA_W | Memory word address (byte units) |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Memory response strobe |
| memRdata | input | 32 | Read data, valid with memAck |
| memErr | input | 1 | Bus error, valid with memAck |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| faultCode | output | 10 | Level in [9:8], fault type in [4:2] |
| physAddr | output | PA_W | Page-aligned physical address |
| pageSize | output | 2 | 0 = 4 KB, 1 = 256 KB, 2 = 16 MB |
| permWrite | output | 1 | Write permission granted |

## Verification
The bench builds a small set of tables and ends walks at each level. It covers all three leaf sizes, and the offsets must match exactly. A design that used the wrong index field or offset slice returns a wrong address. The fault cases cover every way a walk can stop: invalid entries at the first and last level, a reserved entry, a pointer at the last level, a leaf in the context table, and bus errors at the context and first-level reads. Each must carry the right level tag, so a walker that counted levels off by one, or confused the two fault types, is caught. The same leaf is read and then written, so the bench sees a writeback setting only the referenced bit, then another setting the modified bit, then no writeback once both are set. A held `reqValid` and the bypass and boot cases show up as extra completions, stray memory traffic, or a wrong address if mishandled.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_WAIT,
    S_DECODE,
    S_WRITEBACK,
    S_DONE
  } twState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       start;
    logic       bypassGo;
    logic       capture;
    logic       advance;
    logic       leaf;
    logic       fault;
    logic [2:0] faultType;
  } twStrobe_t;

  localparam logic [1:0] ENT_INVALID  = 2'd0;
  localparam logic [1:0] ENT_POINTER  = 2'd1;
  localparam logic [1:0] ENT_LEAF     = 2'd2;
  localparam logic [1:0] ENT_RESERVED = 2'd3;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_OTHER   = 3'd4;

  localparam int REF_BIT = 5;
  localparam int MOD_BIT = 6;

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_256K = 2'd1;
  localparam logic [1:0] SZ_16M  = 2'd2;

  localparam logic [1:0] LAST_LEVEL = 2'd3;

endpackage

// File: rtl/tw_dpath.sv
module tw_dpath
  import tw_pkg::*;
#(
  parameter int PA_W      = 36,
  parameter int CTX_W     = 8,
  parameter int BOOT_BITS = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  twStrobe_t        strobe,
  input  logic [31:0]      reqVa,
  input  logic             reqWrite,
  input  logic             reqFetch,
  input  logic             bootMode,
  input  logic [31:0]      ctxRoot,
  input  logic [CTX_W-1:0] ctxNum,
  input  logic [PA_W-1:0]  romBase,
  input  logic [31:0]      memRdata,
  input  logic             memErr,
  output logic [1:0]       entryType,
  output logic [1:0]       level,
  output logic             busErr,
  output logic             needWb,
  output logic [PA_W-1:0]  memAddr,
  output logic [31:0]      memWdata,
  output logic [PA_W-1:0]  physAddr,
  output logic [1:0]       pageSize,
  output logic             fault,
  output logic [9:0]       faultCode,
  output logic             permWrite
);

  logic [31:0]     vaR;
  logic            wrR;
  logic [1:0]      levelR;
  logic [PA_W-1:0] addrR;
  logic [31:0]     wordR;
  logic            busErrR;
  logic [PA_W-1:0] physR;
  logic [1:0]      sizeR;
  logic            faultR;
  logic [9:0]      codeR;
  logic            permR;

  logic [PA_W-1:0] ctxAddr;
  logic [PA_W-1:0] tableBase;
  logic [9:0]      tableIdx;
  logic [PA_W-1:0] nextAddr;
  logic [PA_W-1:0] leafBase;
  logic [PA_W-1:0] pageOff;
  logic [1:0]      leafSize;
  logic [31:0]     markedWord;
  logic [PA_W-1:0] bypassPa;
  logic            bootRedirect;
  logic            unusedBits;

  assign unusedBits = ^{vaR[11:0], reqVa[11:0]};

  // First read address from root pointer and context number
  assign ctxAddr = (PA_W'(ctxRoot) << 4) + (PA_W'(ctxNum) << 2);

  // Next table address
  assign tableBase = PA_W'({wordR[31:2], 6'b0});
  always_comb begin
    case (levelR)
      2'd0:    tableIdx = {vaR[31:24], 2'b00};
      2'd1:    tableIdx = {2'b00, vaR[23:18], 2'b00};
      default: tableIdx = {2'b00, vaR[17:12], 2'b00};
    endcase
  end
  assign nextAddr = tableBase + PA_W'(tableIdx);

  // Leaf mapping
  assign leafBase = PA_W'({wordR[31:8], 12'b0});
  always_comb begin
    case (levelR)
      2'd1: begin
        pageOff  = PA_W'({vaR[23:12], 12'b0});
        leafSize = SZ_16M;
      end
      2'd2: begin
        pageOff  = PA_W'({vaR[17:12], 12'b0});
        leafSize = SZ_256K;
      end
      default: begin
        pageOff  = '0;
        leafSize = SZ_4K;
      end
    endcase
  end

  always_comb begin
    markedWord = wordR;
    markedWord[REF_BIT] = 1'b1;
    if (wrR) markedWord[MOD_BIT] = 1'b1;
  end

  assign needWb = !wordR[REF_BIT] || (wrR && !wordR[MOD_BIT]);

  // Bypass path
  assign bootRedirect = bootMode && reqFetch;
  assign bypassPa = bootRedirect
                  ? (romBase | PA_W'({reqVa[BOOT_BITS-1:12], 12'b0}))
                  : PA_W'({reqVa[31:12], 12'b0});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaR     <= '0;
      wrR     <= 1'b0;
      levelR  <= '0;
      addrR   <= '0;
      wordR   <= '0;
      busErrR <= 1'b0;
      physR   <= '0;
      sizeR   <= SZ_4K;
      faultR  <= 1'b0;
      codeR   <= '0;
      permR   <= 1'b0;
    end else begin
      if (strobe.start) begin
        vaR    <= reqVa;
        wrR    <= reqWrite;
        levelR <= '0;
        addrR  <= ctxAddr;
      end
      if (strobe.bypassGo) begin
        physR  <= bypassPa;
        sizeR  <= SZ_4K;
        permR  <= !bootRedirect;
        faultR <= 1'b0;
        codeR  <= '0;
      end
      if (strobe.capture) begin
        wordR   <= memRdata;
        busErrR <= memErr;
      end
      if (strobe.advance) begin
        addrR  <= nextAddr;
        levelR <= levelR + 2'd1;
      end
      if (strobe.leaf) begin
        physR  <= leafBase + pageOff;
        sizeR  <= leafSize;
        wordR  <= markedWord;
        permR  <= markedWord[MOD_BIT];
        faultR <= 1'b0;
        codeR  <= '0;
      end
      if (strobe.fault) begin
        physR  <= '0;
        sizeR  <= SZ_4K;
        permR  <= 1'b0;
        faultR <= 1'b1;
        codeR  <= {levelR, 3'b000, strobe.faultType, 2'b00};
      end
    end
  end

  assign entryType = wordR[1:0];
  assign level     = levelR;
  assign busErr    = busErrR;
  assign memAddr   = addrR;
  assign memWdata  = wordR;
  assign physAddr  = physR;
  assign pageSize  = sizeR;
  assign fault     = faultR;
  assign faultCode = codeR;
  assign permWrite = permR;

  // R4 R5
  fault_type_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultR |-> (codeR[4:2] == FT_INVALID || codeR[4:2] == FT_OTHER));

  // R2
  level_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> levelR != 2'd0);

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      bypass,
  input  logic [1:0] entryType,
  input  logic [1:0] level,
  input  logic      busErr,
  input  logic      needWb,
  input  logic      memAck,
  output twStrobe_t strobe,
  output logic      memReq,
  output logic      memWe,
  output logic      done
);

  twState_e stateR, stateNext;
  logic     writingR;

  always_comb begin
    strobe    = '0;
    stateNext = stateR;
    memReq    = 1'b0;
    memWe     = 1'b0;
    done      = 1'b0;
    case (stateR)
      S_IDLE: begin
        if (reqValid) begin
          if (bypass) begin
            strobe.bypassGo = 1'b1;
            stateNext       = S_DONE;
          end else begin
            strobe.start = 1'b1;
            stateNext    = S_READ;
          end
        end
      end
      S_READ: begin
        memReq    = 1'b1;
        stateNext = S_WAIT;
      end
      S_WAIT: begin
        if (memAck) begin
          if (writingR) begin
            stateNext = S_DONE;
          end else begin
            strobe.capture = 1'b1;
            stateNext      = S_DECODE;
          end
        end
      end
      S_DECODE: begin
        stateNext = S_DONE;
        if (busErr) begin
          strobe.fault     = 1'b1;
          strobe.faultType = FT_OTHER;
        end else begin
          case (entryType)
            ENT_INVALID: begin
              strobe.fault     = 1'b1;
              strobe.faultType = FT_INVALID;
            end
            ENT_POINTER: begin
              if (level == LAST_LEVEL) begin
                strobe.fault     = 1'b1;
                strobe.faultType = FT_OTHER;
              end else begin
                strobe.advance = 1'b1;
                stateNext      = S_READ;
              end
            end
            ENT_LEAF: begin
              if (level == 2'd0) begin
                strobe.fault     = 1'b1;
                strobe.faultType = FT_OTHER;
              end else begin
                strobe.leaf = 1'b1;
                if (needWb) stateNext = S_WRITEBACK;
              end
            end
            default: begin
              strobe.fault     = 1'b1;
              strobe.faultType = FT_OTHER;
            end
          endcase
        end
      end
      S_WRITEBACK: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        stateNext = S_WAIT;
      end
      S_DONE: begin
        done      = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateR   <= S_IDLE;
      writingR <= 1'b0;
    end else begin
      stateR <= stateNext;
      if (stateR == S_WRITEBACK)  writingR <= 1'b1;
      else if (stateR == S_IDLE)  writingR <= 1'b0;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R10
  busy_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateR != S_IDLE) |-> !(strobe.start || strobe.bypassGo));

endmodule

// File: rtl/tw_top.sv
module tw_top
  import tw_pkg::*;
#(
  parameter int PA_W      = 36,
  parameter int CTX_W     = 8,
  parameter int BOOT_BITS = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [31:0]      reqVa,
  input  logic             reqWrite,
  input  logic             reqFetch,
  input  logic             bypass,
  input  logic             bootMode,
  input  logic [31:0]      ctxRoot,
  input  logic [CTX_W-1:0] ctxNum,
  input  logic [PA_W-1:0]  romBase,
  output logic             memReq,
  output logic             memWe,
  output logic [PA_W-1:0]  memAddr,
  output logic [31:0]      memWdata,
  input  logic             memAck,
  input  logic [31:0]      memRdata,
  input  logic             memErr,
  output logic             done,
  output logic             fault,
  output logic [9:0]       faultCode,
  output logic [PA_W-1:0]  physAddr,
  output logic [1:0]       pageSize,
  output logic             permWrite
);

  twStrobe_t strobe;
  logic [1:0] entryType;
  logic [1:0] level;
  logic       busErr;
  logic       needWb;

  tw_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .bypass    (bypass),
    .entryType (entryType),
    .level     (level),
    .busErr    (busErr),
    .needWb    (needWb),
    .memAck    (memAck),
    .strobe    (strobe),
    .memReq    (memReq),
    .memWe     (memWe),
    .done      (done)
  );

  tw_dpath #(
    .PA_W      (PA_W),
    .CTX_W     (CTX_W),
    .BOOT_BITS (BOOT_BITS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqVa     (reqVa),
    .reqWrite  (reqWrite),
    .reqFetch  (reqFetch),
    .bootMode  (bootMode),
    .ctxRoot   (ctxRoot),
    .ctxNum    (ctxNum),
    .romBase   (romBase),
    .memRdata  (memRdata),
    .memErr    (memErr),
    .entryType (entryType),
    .level     (level),
    .busErr    (busErr),
    .needWb    (needWb),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .physAddr  (physAddr),
    .pageSize  (pageSize),
    .fault     (fault),
    .faultCode (faultCode),
    .permWrite (permWrite)
  );

  // R6
  wb_ref_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> memWdata[REF_BIT]);

endmodule

// File: tb/tw_top_tb.sv
module tw_top_tb;

  localparam int PA_W  = 36;
  localparam int CTX_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [31:0]      reqVa = '0;
  logic             reqWrite = 1'b0;
  logic             reqFetch = 1'b0;
  logic             bypass = 1'b0;
  logic             bootMode = 1'b0;
  logic [31:0]      ctxRoot = 32'h0000_1000;
  logic [CTX_W-1:0] ctxNum = 8'd2;
  logic [PA_W-1:0]  romBase = 36'h0_FF00_0000;
  logic             memReq, memWe;
  logic [PA_W-1:0]  memAddr;
  logic [31:0]      memWdata;
  logic             memAck = 1'b0;
  logic [31:0]      memRdata = '0;
  logic             memErr = 1'b0;
  logic             done, fault, permWrite;
  logic [9:0]       faultCode;
  logic [PA_W-1:0]  physAddr;
  logic [1:0]       pageSize;

  always #2.5 clk = ~clk;

  tw_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
    .reqWrite(reqWrite), .reqFetch(reqFetch), .bypass(bypass),
    .bootMode(bootMode), .ctxRoot(ctxRoot), .ctxNum(ctxNum),
    .romBase(romBase), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .memErr(memErr), .done(done), .fault(fault), .faultCode(faultCode),
    .physAddr(physAddr), .pageSize(pageSize), .permWrite(permWrite)
  );

  int checks = 0;
  int fails = 0;
  int doneCnt = 0;
  int reqCnt = 0;
  int wrCnt = 0;
  bit finished = 0;
  logic [PA_W-1:0] lastWrAddr;
  logic [31:0]     lastWrData;
  logic [PA_W-1:0] errA = 36'h0_0002_000C;
  logic [PA_W-1:0] errB = 36'h0_0001_0014;
  logic [PA_W-1:0] rdLog[$];

  logic [31:0] mem [logic [PA_W-1:0]];

  // Scoreboard queues
  logic [PA_W+13:0] expQ[$];
  string            tagQ[$];

  function automatic logic [PA_W+13:0] pack(bit f, logic [9:0] c,
      logic [PA_W-1:0] pa, logic [1:0] sz, bit pw);
    return {f, c, pa, sz, pw};
  endfunction

  // R3 leaf address from word, va and level
  function automatic logic [PA_W-1:0] leafPa(logic [31:0] w, logic [31:0] va, int lvl);
    logic [PA_W-1:0] base;
    base = PA_W'({w[31:8], 8'h00}) << 4;
    if (lvl == 1) return base + PA_W'({va[23:12], 12'h000});
    if (lvl == 2) return base + PA_W'({va[17:12], 12'h000});
    return base;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Memory model
  initial begin
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      memErr = 1'b0;
      if (memReq) begin
        logic [PA_W-1:0] a;
        logic            we;
        logic [31:0]     wd;
        a = memAddr; we = memWe; wd = memWdata;
        reqCnt++;
        if (we) begin
          mem[a] = wd; wrCnt++; lastWrAddr = a; lastWrData = wd;
        end else begin
          rdLog.push_back(a);
        end
        repeat (1 + (reqCnt % 3)) @(negedge clk);
        memAck   = 1'b1;
        memRdata = (!we && mem.exists(a)) ? mem[a] : 32'h0;
        memErr   = !we && (a == errA || a == errB);
      end
    end
  end

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        logic [PA_W+13:0] act;
        act = {fault, faultCode, physAddr, pageSize, permWrite};
        doneCnt++;
        if (expQ.size() == 0) begin
          check(1'b0, "R10", "unexpected done", 64'(act), 64'h0);
        end else begin
          logic [PA_W+13:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(act == e, t, "result{fault,code,pa,size,perm}", 64'(act), 64'(e));
        end
      end
    end
  end

  task automatic run(logic [31:0] va, bit wr, bit fe, bit byp, bit boot,
                     logic [7:0] ctx, logic [PA_W+13:0] exp, string tag, int hold = 1);
    int c0;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    c0 = doneCnt;
    @(negedge clk);
    reqVa = va; reqWrite = wr; reqFetch = fe; bypass = byp;
    bootMode = boot; ctxNum = ctx; reqValid = 1'b1;
    repeat (hold) @(negedge clk);
    reqValid = 1'b0;
    while (doneCnt == c0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int w0, r0, d0;
    // Tables
    mem[36'h0_0001_0008] = 32'h0000_2001;   // ctx 2 -> L1 @0x20000
    mem[36'h0_0001_000C] = 32'h0000_1002;   // ctx 3 leaf
    mem[36'h0_0001_0010] = 32'h0000_0000;   // ctx 4 invalid
    mem[36'h0_0002_0004] = 32'h0123_4562;   // L1[1] 16MB leaf R,M set
    mem[36'h0_0002_0008] = 32'h0000_3001;   // L1[2] -> L2 @0x30000
    mem[36'h0_0002_0014] = 32'h0000_0000;   // L1[5] invalid
    mem[36'h0_0003_000C] = 32'h0456_7802;   // L2[3] 256KB leaf, R,M clear
    mem[36'h0_0003_0010] = 32'h0000_4001;   // L2[4] -> L3 @0x40000
    mem[36'h0_0003_0020] = 32'h0000_0003;   // L2[8] reserved
    mem[36'h0_0004_001C] = 32'h00AB_CD22;   // L3[7] 4KB leaf, R set
    mem[36'h0_0004_0024] = 32'h0000_5001;   // L3[9] pointer at last level
    mem[36'h0_0004_0028] = 32'h0000_0000;   // L3[10] invalid

    repeat (3) @(negedge clk);
    // R10 reset state
    check(done == 1'b0, "R10", "done in reset", 64'(done), 64'h0);
    check(memReq == 1'b0, "R2", "memReq in reset", 64'(memReq), 64'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R3 16MB leaf; R6 no writeback when R and M set; R7 perm
    w0 = wrCnt;
    run(32'h01AB_C000, 0, 0, 0, 0, 8'd2,
        pack(0, 10'h0, leafPa(32'h0123_4562, 32'h01AB_C000, 1), 2'd2, 1), "R3");
    check(wrCnt == w0, "R6", "no writeback R/M set", 64'(wrCnt), 64'(w0));

    // R3 256KB leaf read; R6 writeback sets ref only; R7 perm withheld
    w0 = wrCnt;
    run(32'h020C_5000, 0, 0, 0, 0, 8'd2,
        pack(0, 10'h0, leafPa(32'h0456_7802, 32'h020C_5000, 2), 2'd1, 0), "R7");
    check(wrCnt == w0 + 1, "R6", "writeback count", 64'(wrCnt), 64'(w0 + 1));
    check(lastWrAddr == 36'h0_0003_000C, "R6", "writeback addr", 64'(lastWrAddr), 64'h3000C);
    check(lastWrData == 32'h0456_7822, "R6", "writeback data read", 64'(lastWrData), 64'h04567822);

    // Same leaf, write access: modified set and written back
    w0 = wrCnt;
    run(32'h020C_5000, 1, 0, 0, 0, 8'd2,
        pack(0, 10'h0, leafPa(32'h0456_7802, 32'h020C_5000, 2), 2'd1, 1), "R7");
    check(lastWrData == 32'h0456_7862 && wrCnt == w0 + 1, "R6", "writeback data write",
          64'(lastWrData), 64'h04567862);

    // R1 R2 three-level walk, read address sequence
    rdLog.delete();
    w0 = wrCnt;
    run(32'h0210_7000, 0, 0, 0, 0, 8'd2,
        pack(0, 10'h0, leafPa(32'h00AB_CD22, 32'h0210_7000, 3), 2'd0, 0), "R3");
    check(rdLog.size() == 4, "R2", "read count 3-level", 64'(rdLog.size()), 64'd4);
    if (rdLog.size() == 4) begin
      check(rdLog[0] == 36'h0_0001_0008, "R1", "context read addr", 64'(rdLog[0]), 64'h10008);
      check(rdLog[1] == 36'h0_0002_0008, "R2", "L1 read addr", 64'(rdLog[1]), 64'h20008);
      check(rdLog[2] == 36'h0_0003_0010, "R2", "L2 read addr", 64'(rdLog[2]), 64'h30010);
      check(rdLog[3] == 36'h0_0004_001C, "R2", "L3 read addr", 64'(rdLog[3]), 64'h4001C);
    end
    check(wrCnt == w0, "R6", "no writeback R set read", 64'(wrCnt), 64'(w0));

    // R4 invalid faults
    run(32'h0500_0000, 0, 0, 0, 0, 8'd2, pack(1, 10'h104, '0, 2'd0, 0), "R4");
    run(32'h0210_A000, 0, 0, 0, 0, 8'd2, pack(1, 10'h304, '0, 2'd0, 0), "R4");
    run(32'h0000_0000, 0, 0, 0, 0, 8'd4, pack(1, 10'h004, '0, 2'd0, 0), "R4");

    // R5 other faults
    run(32'h0220_0000, 0, 0, 0, 0, 8'd2, pack(1, 10'h210, '0, 2'd0, 0), "R5");
    run(32'h0210_9000, 0, 0, 0, 0, 8'd2, pack(1, 10'h310, '0, 2'd0, 0), "R5");
    run(32'h0300_0000, 0, 0, 0, 0, 8'd2, pack(1, 10'h110, '0, 2'd0, 0), "R5");
    run(32'h0000_0000, 0, 0, 0, 0, 8'd3, pack(1, 10'h010, '0, 2'd0, 0), "R5");
    run(32'h0000_0000, 0, 0, 0, 0, 8'd5, pack(1, 10'h010, '0, 2'd0, 0), "R5");

    // R8 bypass, no memory traffic
    r0 = reqCnt;
    run(32'hDEAD_B123, 1, 0, 1, 0, 8'd2, pack(0, 10'h0, 36'h0_DEAD_B000, 2'd0, 1), "R8");
    check(reqCnt == r0, "R8", "bypass memory requests", 64'(reqCnt), 64'(r0));

    // R9 boot redirect for fetch, ignored for data
    run(32'h1237_F456, 0, 1, 1, 1, 8'd2, pack(0, 10'h0, 36'h0_FF07_F000, 2'd0, 0), "R9");
    run(32'h1237_F456, 0, 0, 1, 1, 8'd2, pack(0, 10'h0, 36'h0_1237_F000, 2'd0, 1), "R9");

    // R10 reqValid held during a walk is ignored
    d0 = doneCnt;
    run(32'h01AB_C000, 0, 0, 0, 0, 8'd2,
        pack(0, 10'h0, leafPa(32'h0123_4562, 32'h01AB_C000, 1), 2'd2, 1), "R10", 3);
    repeat (20) @(negedge clk);
    check(doneCnt == d0 + 1, "R10", "single done for held request", 64'(doneCnt), 64'(d0 + 1));
    check(expQ.size() == 0, "R10", "pending results", 64'(expQ.size()), 64'h0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule